// File: doc/BRIEF.md
# UART Interrupt Status, Mask and Line Routing

This block keeps the raw interrupt status word of a UART and the enable mask that goes with it. The neighbouring FIFO, transmit and modem logic raise status bits with one-cycle set pulses. Software sees the state through four views on a small register bus: a read/write enable mask, a read-only raw view, a read-only masked view, and a write-one-to-clear register that always reads as zero. A write to the UART data register also sets the transmit status bit. The event sources and the data path are not part of this block.

From the masked word the block drives six interrupt lines. Five of them each cover one group of status bits: receive, transmit, receive timeout, modem status and error. The sixth is the OR of every masked bit. The lines are combinational functions of the registered raw status and mask. They change in the same cycle that a register write or a set pulse takes effect.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Reset clears the raw status and the enable mask. All six lines are then low, and every register reads zero.
- R2: A 1 on bit k of `evt_set` in a cycle sets raw bit k at the next clock edge. The bit stays set until a clear write removes it. The layout is RI=0, CTS=1, DCD=2, DSR=3, RX=4, TX=5, RT=6, and error bits FE/PE/BE/OE are 7 to 10.
- R3: A write to the data register at word address 0 sets raw bit 5 (TX) and changes no other bit.
- R4: A write to the clear register at word address 4 clears each raw bit where the write data holds a 1 and leaves the other bits alone. Reading address 4 returns zero.
- R5: If a set pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R6: A write to the mask register at word address 1 replaces the whole 11-bit enable mask. Reading address 1 returns the mask.
- R7: Reading address 2 returns the raw status. Reading address 3 returns raw AND mask. Writes to address 2 or 3 change no state.
- R8: `irq_rx`, `irq_tx` and `irq_rt` follow masked bits 4, 5 and 6. `irq_ms` is high when any of masked bits 0 to 3 is set. `irq_err` is high when any of masked bits 7 to 10 is set.
- R9: `irq_any` is high exactly when any masked bit is set.
- R10: Read bits 11 to 31 are zero in every register, and mask write bits 11 to 31 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| evt_set | input | 11 | Per-bit set pulses from the event sources |
| irq_any | output | 1 | Combined interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rt | output | 1 | Receive timeout interrupt line |
| irq_ms | output | 1 | Modem status interrupt line |
| irq_err | output | 1 | Error interrupt line |

## Verification
The checks that run on every cycle cover four things:
- Set pulses stick in the raw word.
- Data writes raise TX, and clear writes leave no unprotected written bit set.
- A mask write is taken whole.
- Raw status holds still when nothing acts on it, and the combined line always agrees with the masked word.

Some behaviour shows only through the bench's own scenarios:
- The group fan-out on each individual line.
- Readback through every view, including the zero upper bits and the zero clear register.
- Set-over-clear in a collision.
- Writes to the read-only views being ignored.

A model in the bench tracks all of these.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NBITS = 11;
    localparam int NLINES = 5;

    localparam int BIT_TX = 5;

    typedef enum logic [2:0] {
        SEL_DATA   = 3'd0,
        SEL_MASK   = 3'd1,
        SEL_RAW    = 3'd2,
        SEL_MASKED = 3'd3,
        SEL_CLEAR  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [NBITS-1:0] raw;
        logic [NBITS-1:0] mask;
    } irq_state_t;

    // line index: 0 rx, 1 tx, 2 rt, 3 modem status, 4 error
    function automatic logic [NBITS-1:0] line_group(input int idx);
        case (idx)
            0:       line_group = 11'h010;
            1:       line_group = 11'h020;
            2:       line_group = 11'h040;
            3:       line_group = 11'h00F;
            default: line_group = 11'h780;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_dec.sv
module uart_irq_dec
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NBITS-1:0]  raw_q,
    input  logic [NBITS-1:0]  mask_q,
    output logic              wr_data,
    output logic              wr_mask,
    output logic              wr_clear,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - NBITS;

    always_comb begin
        wr_data  = bus_wr && (bus_addr == ADDR_W'(SEL_DATA));
        wr_mask  = bus_wr && (bus_addr == ADDR_W'(SEL_MASK));
        wr_clear = bus_wr && (bus_addr == ADDR_W'(SEL_CLEAR));
    end

    always_comb begin
        rdata = '0;
        if (bus_addr == ADDR_W'(SEL_MASK)) begin
            rdata = {{PAD_W{1'b0}}, mask_q};
        end else if (bus_addr == ADDR_W'(SEL_RAW)) begin
            rdata = {{PAD_W{1'b0}}, raw_q};
        end else if (bus_addr == ADDR_W'(SEL_MASKED)) begin
            rdata = {{PAD_W{1'b0}}, raw_q & mask_q};
        end
    end
endmodule

// File: rtl/uart_irq_state.sv
module uart_irq_state
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_data,
    input  logic             wr_mask,
    input  logic             wr_clear,
    input  logic [NBITS-1:0] wbits,
    input  logic [NBITS-1:0] evt_set,
    output logic [NBITS-1:0] raw_q,
    output logic [NBITS-1:0] mask_q
);
    irq_state_t st_d, st_q;
    logic [NBITS-1:0] set_vec;
    logic [NBITS-1:0] clr_vec;

    always_comb begin
        set_vec = evt_set;
        if (wr_data) begin
            set_vec[BIT_TX] = 1'b1;
        end
        clr_vec = wr_clear ? wbits : '0;
        st_d = st_q;
        // set has priority over clear on the same bit
        st_d.raw = (st_q.raw & ~clr_vec) | set_vec;
        if (wr_mask) begin
            st_d.mask = wbits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_q  = st_q.raw;
    assign mask_q = st_q.mask;
endmodule

// File: rtl/uart_irq_route.sv
module uart_irq_route
    import uart_irq_pkg::*;
(
    input  logic [NBITS-1:0]  raw_q,
    input  logic [NBITS-1:0]  mask_q,
    output logic [NLINES-1:0] lines,
    output logic              any
);
    logic [NBITS-1:0] masked;

    assign masked = raw_q & mask_q;

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        localparam logic [NBITS-1:0] GRP = line_group(g);
        assign lines[g] = |(masked & GRP);
    end

    assign any = |lines;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NBITS-1:0]  evt_set,
    output logic              irq_any,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_rt,
    output logic              irq_ms,
    output logic              irq_err
);
    logic             wr_data, wr_mask, wr_clear;
    logic [NBITS-1:0] raw_vec, mask_vec;
    logic [NLINES-1:0] lines;

    uart_irq_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .raw_q    (raw_vec),
        .mask_q   (mask_vec),
        .wr_data  (wr_data),
        .wr_mask  (wr_mask),
        .wr_clear (wr_clear),
        .rdata    (bus_rdata)
    );

    uart_irq_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (wr_data),
        .wr_mask  (wr_mask),
        .wr_clear (wr_clear),
        .wbits    (bus_wdata[NBITS-1:0]),
        .evt_set  (evt_set),
        .raw_q    (raw_vec),
        .mask_q   (mask_vec)
    );

    uart_irq_route u_route (
        .raw_q  (raw_vec),
        .mask_q (mask_vec),
        .lines  (lines),
        .any    (irq_any)
    );

    assign irq_rx  = lines[0];
    assign irq_tx  = lines[1];
    assign irq_rt  = lines[2];
    assign irq_ms  = lines[3];
    assign irq_err = lines[4];
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NBITS-1:0]  evt_set,
    input logic [NBITS-1:0]  raw_vec,
    input logic [NBITS-1:0]  mask_vec,
    input logic              irq_any
);
    // R2
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (|evt_set)) |=> ((raw_vec & $past(evt_set)) == $past(evt_set)));

    // R3
    data_sets_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(SEL_DATA)) |=> raw_vec[BIT_TX]);

    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(SEL_CLEAR)) |=>
        ((raw_vec & $past(bus_wdata[NBITS-1:0]) & ~$past(evt_set)) == '0));

    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(SEL_MASK)) |=> (mask_vec == $past(bus_wdata[NBITS-1:0])));

    // R7
    raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set == '0 && !(bus_wr && (bus_addr == ADDR_W'(SEL_CLEAR) ||
                                       bus_addr == ADDR_W'(SEL_DATA)))) |=> $stable(raw_vec));

    // R9
    any_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (|(raw_vec & mask_vec)));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_set   (evt_set),
    .raw_vec   (raw_vec),
    .mask_vec  (mask_vec),
    .irq_any   (irq_any)
);

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
    localparam int AW = 3;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [10:0]   evt_set = '0;
    logic irq_any, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [10:0] m_raw = '0;
    logic [10:0] m_mask = '0;

    always #4 clk = ~clk;

    uart_irq_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
        .irq_any(irq_any), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_rt(irq_rt),
        .irq_ms(irq_ms), .irq_err(irq_err)
    );

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        case (a)
            3'd1:    exp_read = {21'd0, m_mask};
            3'd2:    exp_read = {21'd0, m_raw};
            3'd3:    exp_read = {21'd0, m_raw & m_mask};
            default: exp_read = 32'd0;
        endcase
    endfunction

    function automatic logic [5:0] exp_lines();
        logic [10:0] mk;
        mk = m_raw & m_mask;
        // {any, err, ms, rt, tx, rx}
        exp_lines = {|mk, |mk[10:7], |mk[3:0], mk[6], mk[5], mk[4]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_lines(input string req);
        check(req, {26'd0, irq_any, irq_err, irq_ms, irq_rt, irq_tx, irq_rx}, {26'd0, exp_lines()});
    endtask

    task automatic step(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                        input logic [10:0] ev);
        logic [10:0] clr;
        logic [10:0] setv;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; evt_set = ev;
        @(posedge clk);
        clr  = (wr && a == 3'd4) ? d[10:0] : 11'd0;
        setv = ev | ((wr && a == 3'd0) ? 11'h020 : 11'd0);
        m_raw = (m_raw & ~clr) | setv;
        if (wr && a == 3'd1) m_mask = d[10:0];
        #1;
        bus_wr = 1'b0; evt_set = '0;
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input string req);
        @(negedge clk);
        bus_wr = 1'b0; evt_set = '0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp_read(a));
    endtask

    task automatic read_all(input string req);
        for (int k = 0; k < 5; k++) read_chk(AW'(k), req);
    endtask

    initial begin : watchdog
        #1000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check_lines("R1");
        read_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        read_all("R1");

        // R6 mask readback, R10 upper bits dropped
        step(1'b1, 3'd1, 32'hFFFF_FFFF, 11'd0);
        read_chk(3'd1, "R6 R10");
        // R2 each event bit sets and sticks
        for (int b = 0; b < 11; b++) begin
            step(1'b0, 3'd0, 32'd0, 11'(1 << b));
            read_chk(3'd2, "R2");
            check_lines("R8");
        end
        step(1'b0, 3'd0, 32'd0, 11'd0);
        read_chk(3'd2, "R2 sticky");
        // R4 partial clear, clear reads zero
        step(1'b1, 3'd4, 32'h0000_0155, 11'd0);
        read_chk(3'd2, "R4");
        read_chk(3'd4, "R4 read zero");
        check_lines("R9");
        // R7 writes to raw and masked views ignored
        step(1'b1, 3'd2, 32'hFFFF_FFFF, 11'd0);
        read_chk(3'd2, "R7 raw write");
        step(1'b1, 3'd3, 32'h0000_0000, 11'd0);
        read_chk(3'd3, "R7 masked write");
        read_chk(3'd2, "R7");
        // R5 collision: set and clear the same bit
        step(1'b1, 3'd4, 32'h0000_07FF, 11'h440);
        read_chk(3'd2, "R5");
        // R3 data write sets TX only
        step(1'b1, 3'd4, 32'h0000_07FF, 11'd0);
        step(1'b1, 3'd0, 32'h0000_0041, 11'd0);
        read_chk(3'd2, "R3");
        check_lines("R8 tx");
        // R6 mask replace, lines follow immediately
        step(1'b1, 3'd1, 32'h0000_0010, 11'd0);
        check_lines("R6 R9");
        read_chk(3'd3, "R7 masked");

        // random phase
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [AW-1:0] a;
            logic [31:0] d;
            logic [10:0] ev;
            op = int'($urandom_range(0, 9));
            d  = $urandom();
            ev = ($urandom_range(0, 3) == 0) ? 11'($urandom()) : 11'd0;
            a  = AW'($urandom_range(0, 7));
            step(op < 6, a, d, ev);
            check_lines("R8 R9 random");
            if (op == 9) read_chk(AW'($urandom_range(0, 7)), "R7 R10 random");
        end
        read_all("R7 final");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule